// File: doc/BRIEF.md
# Secondary Cache Tag Store with Index Maintenance

This block keeps the tag entries of an off-chip secondary cache and carries out the two index-addressed maintenance operations that move one entry between the tag store and the coprocessor TagLo register. A decoded maintenance request arrives with its 5-bit operation code, the virtual address, the already translated physical address, the current TagLo value and the privilege status bits. The block checks privilege, derives an entry index from the physical address, and then reads an entry into TagLo or writes one from it. Address translation, ECC, cache data and hit-based operations are outside its scope.

Each stored entry is 25 bits wide. From the top: a 3-bit line state in bits 24:22, a 3-bit primary-cache index in bits 21:19, and a 19-bit physical tag in bits 18:0. TagLo uses a different layout. The tag sits in bits 31:13, the state in bits 12:10 and the primary index in bits 9:7. The block repacks between the two layouts. Cache size and line size are parameters. The size need not be a power of two, so a masked address can point past the last entry, and that case is reported as an error.

A request is taken in any cycle in which `req_valid` is high. The controller is a small state machine whose state records the outcome of the previous cycle's request. `ST_IDLE` means no request. `ST_LOAD_DONE` means a tag was read into TagLo, and `ST_STORE_DONE` means an entry was written. `ST_NOP_DONE` covers a code this block does not act on, or a cache that is absent. `ST_PRIV_FAULT` means the request was blocked by privilege, and `ST_RANGE_FAULT` means the index was past the last entry. Each clock edge moves the machine from its current state to whichever state the request present at that edge selects; it returns to `ST_IDLE` when no request is present. Outputs are decoded from the state.

Top module: `sctag_ctrl`

## Requirements
- R1: `req_op` values 0x06 and 0x07 mean load tag, and 0x0A and 0x0B mean store tag. Any other code completes with `done` but changes neither the array nor `taglo_out`.
- R2: A request is blocked when `stat_ksu` is nonzero, `stat_cu0` is 0, and both `stat_exl` and `stat_erl` are 0. The block then raises `cpu_exc` for the cycle after the request, and neither the array nor `taglo_out` changes. This check takes priority over every other outcome.
- R3: The entry index is `(req_paddr & (CACHE_BYTES-1)) >> SHIFT`, so addresses that differ only in masked-off bits reach the same entry.
- R4: SHIFT is 4 for lines of 16 bytes or less, 5 for lines up to 32, 6 for lines up to 64, and 7 otherwise. `cfg_line_sel` outputs SHIFT-4.
- R5: In the cycle after a load, `taglo_out` holds the entry's tag in bits 31:13, its state in 12:10, its primary index in 9:7, and zero in bits 6:0.
- R6: A store writes state `taglo_in[12:10]`, tag `taglo_in[31:13]` and primary index `req_vaddr[14:12]` on the accepting edge. A load in the next cycle returns the written entry. A store leaves `taglo_out` unchanged.
- R7: An index at or above CACHE_BYTES>>SHIFT raises `idx_err` for one cycle. It changes neither the array nor `taglo_out`.
- R8: With CACHE_BYTES equal to 0, `cfg_sc_absent` is 1, and every request completes with `done` while leaving `taglo_out` at its value.
- R9: `done` is high in exactly the cycle after each accepted request, and is low in the cycle after a cycle with no request.
- R10: After reset, `taglo_out`, `done`, `cpu_exc` and `idx_err` are 0, and every entry holds state 0, index 0 and tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Maintenance request present this cycle |
| req_op | input | 5 | Operation code |
| req_vaddr | input | 32 | Virtual address; bits 14:12 supply the primary index |
| req_paddr | input | 32 | Translated physical address |
| taglo_in | input | 32 | Current TagLo value |
| stat_ksu | input | 2 | Privilege mode field |
| stat_cu0 | input | 1 | Coprocessor 0 usable |
| stat_exl | input | 1 | Exception level |
| stat_erl | input | 1 | Error level |
| taglo_out | output | 32 | TagLo value produced by loads |
| done | output | 1 | Request completed (previous cycle) |
| cpu_exc | output | 1 | Coprocessor-unusable exception |
| idx_err | output | 1 | Index beyond last entry |
| cfg_line_sel | output | 2 | Line-size code for the configuration register |
| cfg_sc_absent | output | 1 | No secondary cache configured |

## Verification
The assertions assume that the privilege and operation inputs are stable around the clock edge. They also assume that the physical address is already translated, so an out-of-range index can come only from the masked address. The stimulus drives requests at the falling edge and holds each one for exactly one cycle. It runs single requests, back-to-back requests and idle gaps, and it changes the status bits only together with a request. The default size of 1000 bytes is not a power of two, which lets the stimulus reach the out-of-range index with an ordinary address.

// File: rtl/sctag_pkg.sv
package sctag_pkg;

    typedef struct packed {
        logic [2:0]  cs;
        logic [2:0]  pidx;
        logic [18:0] ptag;
    } sc_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_DONE,
        ST_STORE_DONE,
        ST_NOP_DONE,
        ST_PRIV_FAULT,
        ST_RANGE_FAULT
    } sc_state_t;

    typedef enum logic [1:0] {
        OPK_OTHER,
        OPK_LOAD,
        OPK_STORE
    } op_kind_t;

    function automatic int line_shift(input int line_bytes);
        if (line_bytes <= 16)      return 4;
        else if (line_bytes <= 32) return 5;
        else if (line_bytes <= 64) return 6;
        else                       return 7;
    endfunction

    function automatic op_kind_t decode_op(input logic [4:0] op);
        unique case (op)
            5'h06, 5'h07: return OPK_LOAD;
            5'h0A, 5'h0B: return OPK_STORE;
            default:      return OPK_OTHER;
        endcase
    endfunction

    function automatic logic [31:0] pack_taglo(input sc_entry_t e);
        return {e.ptag, e.cs, e.pidx, 7'b0};
    endfunction

endpackage

// File: rtl/sctag_index.sv
module sctag_index #(
    parameter int CACHE_BYTES = 1000,
    parameter int SHIFT       = 4,
    parameter int ENTRIES     = 62,
    parameter int IDX_W       = 6
) (
    input  logic [31:0]      paddr,
    output logic [IDX_W-1:0] idx,
    output logic             in_range
);
    localparam logic [31:0] MASK = 32'(CACHE_BYTES - 1);

    logic [31:0] full_idx;

    always_comb begin
        full_idx = (paddr & MASK) >> SHIFT;
        in_range = full_idx < 32'(ENTRIES);
        idx      = full_idx[IDX_W-1:0];
    end
endmodule

// File: rtl/sctag_array.sv
module sctag_array
    import sctag_pkg::*;
#(
    parameter int DEPTH = 62,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  sc_entry_t        wdata,
    input  logic [IDX_W-1:0] raddr,
    output sc_entry_t        rdata
);
    localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

    sc_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if ({1'b0, raddr} < DEPTH_L) rdata = mem[raddr];
        else                         rdata = '0;
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < DEPTH_L)); // R7
endmodule

// File: rtl/sctag_ctrl.sv
module sctag_ctrl
    import sctag_pkg::*;
#(
    parameter int CACHE_BYTES = 1000,
    parameter int LINE_BYTES  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [4:0]  req_op,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_paddr,
    input  logic [31:0] taglo_in,
    input  logic [1:0]  stat_ksu,
    input  logic        stat_cu0,
    input  logic        stat_exl,
    input  logic        stat_erl,
    output logic [31:0] taglo_out,
    output logic        done,
    output logic        cpu_exc,
    output logic        idx_err,
    output logic [1:0]  cfg_line_sel,
    output logic        cfg_sc_absent
);
    localparam int SHIFT   = line_shift(LINE_BYTES);
    localparam bit PRESENT = CACHE_BYTES > 0;
    localparam int ENTRIES = PRESENT ? (CACHE_BYTES >> SHIFT) : 0;
    localparam int DEPTH   = (ENTRIES > 0) ? ENTRIES : 1;
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    sc_state_t        state, state_nx;
    op_kind_t         kind;
    logic             priv_block;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             arr_we;
    sc_entry_t        wr_entry, rd_entry;
    logic [31:0]      taglo_q;
    logic             unused_in;

    assign unused_in = ^{req_vaddr[31:15], req_vaddr[11:0], taglo_in[9:0]};

    sctag_index #(
        .CACHE_BYTES (CACHE_BYTES),
        .SHIFT       (SHIFT),
        .ENTRIES     (ENTRIES),
        .IDX_W       (IDX_W)
    ) i_index (
        .paddr    (req_paddr),
        .idx      (idx),
        .in_range (in_range)
    );

    always_comb begin
        priv_block = (stat_ksu != 2'b00) && !stat_cu0 && !(stat_exl || stat_erl);
        kind       = decode_op(req_op);
        wr_entry   = '{cs: taglo_in[12:10], pidx: req_vaddr[14:12], ptag: taglo_in[31:13]};

        if (!req_valid)                       state_nx = ST_IDLE;
        else if (priv_block)                  state_nx = ST_PRIV_FAULT;
        else if (kind == OPK_OTHER || !PRESENT) state_nx = ST_NOP_DONE;
        else if (!in_range)                   state_nx = ST_RANGE_FAULT;
        else if (kind == OPK_LOAD)            state_nx = ST_LOAD_DONE;
        else                                  state_nx = ST_STORE_DONE;

        arr_we = (state_nx == ST_STORE_DONE);
    end

    generate
        if (PRESENT) begin : g_arr
            sctag_array #(
                .DEPTH (DEPTH),
                .IDX_W (IDX_W)
            ) i_array (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (arr_we),
                .waddr (idx),
                .wdata (wr_entry),
                .raddr (idx),
                .rdata (rd_entry)
            );
        end else begin : g_none
            logic unused_absent;
            assign unused_absent = ^{arr_we, wr_entry, idx, in_range};
            assign rd_entry      = '0;
        end
    endgenerate

    // state register, plus the TagLo capture it selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            taglo_q <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_LOAD_DONE) taglo_q <= pack_taglo(rd_entry);
        end
    end

    // outputs decoded from state
    always_comb begin
        done    = 1'b0;
        cpu_exc = 1'b0;
        idx_err = 1'b0;
        unique case (state)
            ST_IDLE:        ;
            ST_LOAD_DONE,
            ST_STORE_DONE,
            ST_NOP_DONE:    done = 1'b1;
            ST_PRIV_FAULT:  begin done = 1'b1; cpu_exc = 1'b1; end
            ST_RANGE_FAULT: begin done = 1'b1; idx_err = 1'b1; end
            default:        ;
        endcase
        taglo_out     = taglo_q;
        cfg_line_sel  = 2'(SHIFT - 4);
        cfg_sc_absent = !PRESENT;
    end

    AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_block) |=> (cpu_exc && $stable(taglo_out))); // R2
    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv_block && kind != OPK_OTHER && PRESENT && !in_range)
        |=> (idx_err && $stable(taglo_out))); // R7
    AST_LOAD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_DONE) |-> (taglo_out[6:0] == 7'd0)); // R5
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R9
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done); // R9
    AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sc_absent |=> $stable(taglo_out)); // R8
    AST_STORE_KEEPS_TAGLO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == OPK_STORE) |=> $stable(taglo_out)); // R6
endmodule

// File: tb/test_sctag_ctrl.sv
module test_sctag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SIZE       = 1000;
    localparam int NENT       = 62;

    typedef struct {
        logic [31:0] taglo;
        logic        done;
        logic        exc;
        logic        err;
        int          rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_op = '0;
    logic [31:0] req_vaddr = '0, req_paddr = '0, taglo_in = '0;
    logic [1:0]  stat_ksu = '0;
    logic        stat_cu0 = 1'b1, stat_exl = 1'b0, stat_erl = 1'b0;

    logic [31:0] taglo_out, a_taglo;
    logic        done, cpu_exc, idx_err, a_done, a_exc, a_err;
    logic [1:0]  cfg_line_sel, a_line;
    logic        cfg_sc_absent, a_absent;

    int total = 0, bad = 0;
    bit finished = 0;
    exp_t sb[$];
    logic [24:0] ref_mem [64];
    logic [31:0] ref_taglo = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sctag_ctrl #(.CACHE_BYTES(SIZE), .LINE_BYTES(16)) i_sctag_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_vaddr(req_vaddr), .req_paddr(req_paddr), .taglo_in(taglo_in),
        .stat_ksu(stat_ksu), .stat_cu0(stat_cu0), .stat_exl(stat_exl), .stat_erl(stat_erl),
        .taglo_out(taglo_out), .done(done), .cpu_exc(cpu_exc), .idx_err(idx_err),
        .cfg_line_sel(cfg_line_sel), .cfg_sc_absent(cfg_sc_absent));

    sctag_ctrl #(.CACHE_BYTES(0), .LINE_BYTES(64)) i_sctag_ctrl_absent (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_vaddr(req_vaddr), .req_paddr(req_paddr), .taglo_in(taglo_in),
        .stat_ksu(stat_ksu), .stat_cu0(stat_cu0), .stat_exl(stat_exl), .stat_erl(stat_erl),
        .taglo_out(a_taglo), .done(a_done), .cpu_exc(a_exc), .idx_err(a_err),
        .cfg_line_sel(a_line), .cfg_sc_absent(a_absent));

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // driver: applies one request at the falling edge and queues what must follow
    task automatic drive(input logic [4:0] op, input logic [31:0] va, input logic [31:0] pa,
                         input logic [31:0] tin, input logic [1:0] ksu, input logic cu0,
                         input logic exl, input logic erl, input int rq);
        exp_t e;
        int   idx;
        bit   priv;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_vaddr = va; req_paddr = pa; taglo_in = tin;
        stat_ksu = ksu; stat_cu0 = cu0; stat_exl = exl; stat_erl = erl;
        priv = (ksu != 0) && !cu0 && !exl && !erl;
        idx  = int'((pa & 32'(SIZE-1)) >> 4);
        e = '{taglo: ref_taglo, done: 1'b1, exc: 1'b0, err: 1'b0, rq: rq};
        if (priv) e.exc = 1'b1;
        else if (op inside {5'h06, 5'h07, 5'h0A, 5'h0B}) begin
            if (idx >= NENT) e.err = 1'b1;
            else if (op inside {5'h06, 5'h07}) begin
                ref_taglo = {ref_mem[idx][18:0], ref_mem[idx][24:22], ref_mem[idx][21:19], 7'b0};
                e.taglo = ref_taglo;
            end else
                ref_mem[idx] = {tin[12:10], va[14:12], tin[31:13]};
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        stat_ksu = '0; stat_cu0 = 1'b1; stat_exl = 1'b0; stat_erl = 1'b0;
    endtask

    // monitor: compares each result one step after the edge it belongs to
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (taglo_out !== e.taglo || done !== e.done || cpu_exc !== e.exc || idx_err !== e.err) begin
                bad++;
                $display("FAIL R%0d actual taglo=%h d/x/e=%b%b%b expected taglo=%h d/x/e=%b%b%b",
                         e.rq, taglo_out, done, cpu_exc, idx_err, e.taglo, e.done, e.exc, e.err);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state and R4 line-size field
        check(taglo_out == 0 && !done && !cpu_exc && !idx_err, "R10", {29'd0, done, cpu_exc, idx_err}, 0);
        check(cfg_line_sel == 2'd0, "R4", 32'(cfg_line_sel), 0);
        check(a_line == 2'd2, "R4", 32'(a_line), 2);
        check(!cfg_sc_absent, "R8", 32'(cfg_sc_absent), 0);
        rst_n = 1'b1;

        drive(5'h06, 0, 32'h0000_0040, 0, 0, 1, 0, 0, 10);             // R10 entry cleared
        idle();
        drive(5'h0A, 32'h0000_5000, 32'h0000_0040, 32'hABCD_E000 | (5 << 10) | 32'h3FF, 0, 1, 0, 0, 6); // R6
        drive(5'h07, 0, 32'h0000_0040, 0, 0, 1, 0, 0, 5);              // R5 load
        drive(5'h0B, 32'h0000_7000, 32'h0000_03C0, 32'hFFFF_E000 | (7 << 10), 0, 1, 0, 0, 6); // R6
        drive(5'h0A, 32'h0000_1234, 32'h0000_0020, 32'h0000_2000 | (1 << 10), 0, 1, 0, 0, 6); // R6
        drive(5'h07, 0, 32'h0000_03C0, 0, 0, 1, 0, 0, 9);              // R9 back to back
        drive(5'h06, 0, 32'h0000_0020, 0, 0, 1, 0, 0, 9);              // R9
        idle();
        @(posedge clk); #2;
        check(!done, "R9", 32'(done), 0);
        drive(5'h06, 0, 32'h0000_0440, 0, 0, 1, 0, 0, 3);              // R3 alias of entry 4
        drive(5'h06, 0, 32'h0000_0020, 0, 0, 1, 0, 0, 3);
        drive(5'h08, 32'h0000_3000, 32'h0000_0040, 32'h1111_E000, 0, 1, 0, 0, 1); // R1 ignored code
        drive(5'h1F, 0, 32'h0000_0040, 32'h2222_E000, 0, 1, 0, 0, 1);  // R1
        drive(5'h06, 0, 32'h0000_0040, 0, 0, 1, 0, 0, 1);              // R1 entry intact
        drive(5'h0A, 32'h0000_6000, 32'h0000_0040, 32'h5555_E000, 2'd2, 0, 0, 0, 2); // R2 blocked
        drive(5'h06, 0, 32'h0000_0020, 0, 2'd3, 0, 0, 0, 2);           // R2 blocked load
        drive(5'h06, 0, 32'h0000_0040, 0, 2'd2, 1, 0, 0, 2);           // R2 cu0 allows
        drive(5'h06, 0, 32'h0000_03C0, 0, 2'd1, 0, 1, 0, 2);           // R2 exl allows
        drive(5'h06, 0, 32'h0000_0020, 0, 2'd1, 0, 0, 1, 2);           // R2 erl allows
        drive(5'h06, 0, 32'h0000_03E0, 0, 0, 1, 0, 0, 7);              // R7 range load
        drive(5'h0B, 32'h0000_2000, 32'h0000_03E0, 32'h7777_E000, 0, 1, 0, 0, 7); // R7 range store
        drive(5'h07, 0, 32'h0000_0040, 0, 0, 1, 0, 0, 7);
        idle();
        @(posedge clk); #2;
        // R8 absent instance never changed its TagLo and flags absence
        check(a_absent && a_taglo == 0, "R8", a_taglo, 0);
        drive(5'h06, 0, 32'h0000_0040, 0, 0, 1, 0, 0, 8);
        @(posedge clk); #2;
        check(a_done && !a_err && a_taglo == 0, "R8", {a_taglo[30:0], a_done}, 1);
        idle();
        repeat (3) @(posedge clk);
        #2;
        check(sb.size() == 0, "R9", 32'(sb.size()), 0);
        finish_run();
    end
endmodule